// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block stretches a system reset. It takes three kinds of request: a synchronous supply-good indication, an edge applied from outside to either of the two reset pins, and a one-cycle watchdog time-out request. It answers each request with a reset pulse of fixed length. The length is counted in strobes of a slow tick, nominally 5 kHz. The default of 1000 ticks gives about 200 ms.

Both reset pins are open drain. The active-high pin is pulled down when it is not driven, and the active-low pin is pulled up. The block drives each pin with a drive-enable and reads back the level sensed on it. Each sensed level passes through a two-flop synchronizer before edge detection. The block masks the edges that its own drive causes, so that it does not restart itself. A flag shows the reset-in-progress period to other logic. A second flag marks the first pulse after supply-good rises.

Top module: `sup_reset_pulse`

## Requirements
- R1: While `supply_ok` is 0, `rst_hi_oe` and `rst_lo_oe` are 1 in the same cycle, with no register between `supply_ok` and the outputs.
- R2: After `supply_ok` rises, the outputs stay asserted for exactly `PULSE_TICKS` tick strobes, counted from the rising cycle itself, and are then released.
- R3: `rst_hi_oe`, `rst_lo_oe` and `reset_active` are always equal, so both pins assert and release together.
- R4: With `supply_ok` at 1, a `wdt_expire` cycle asserts the outputs from the next cycle on, for a full `PULSE_TICKS` ticks counted from the cycle after the request.
- R5: A 0-to-1 change of the sensed `rst_hi_pin` while the block is not driving asserts the outputs within 3 cycles, and starts a full pulse.
- R6: A 1-to-0 change of the sensed `rst_lo_pin` while the block is not driving asserts the outputs within 3 cycles, and starts a full pulse.
- R7: Two kinds of pin change start no pulse: pin changes that follow from the block's own drive, and changes in the inactive direction (`rst_hi_pin` falling, `rst_lo_pin` rising).
- R8: A request that comes during a pulse reloads the counter. A request takes priority over a tick in the same cycle, even when that tick is the last one, so the pulse ends `PULSE_TICKS` ticks after the last request.
- R9: `powerup_hold` is 1 from the cycle after `supply_ok` rises until the first pulse ends. It is 0 during pulses started by the watchdog or by a pin.
- R10: During `rst_n` low the outputs are asserted and `powerup_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe from the slow oscillator |
| supply_ok | input | 1 | Synchronous supply-good indication |
| wdt_expire | input | 1 | Watchdog time-out request, one cycle |
| rst_hi_pin | input | 1 | Level sensed on the active-high pin |
| rst_lo_pin | input | 1 | Level sensed on the active-low pin |
| rst_hi_oe | output | 1 | Drive-enable that pulls the active-high pin up |
| rst_lo_oe | output | 1 | Drive-enable that pulls the active-low pin down |
| reset_active | output | 1 | Reset in progress |
| powerup_hold | output | 1 | First pulse after supply-good rises is in progress |

## Verification
A new request can land in the same cycle as the tick that would end a pulse. The bench counts ticks during a watchdog pulse and raises `wdt_expire` in exactly the cycle of the final tick. It then checks that the outputs stay asserted and that a complete new pulse of `PULSE_TICKS` ticks follows. Supply-good rising and a tick in the same cycle is the other overlap. There the bench expects that tick to count toward the power-up pulse.

// File: rtl/sup_reset_pulse.sv
module sup_reset_pulse #(
  parameter int PULSE_TICKS = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wdt_expire,
  input  logic rst_hi_pin,
  input  logic rst_lo_pin,
  output logic rst_hi_oe,
  output logic rst_lo_oe,
  output logic reset_active,
  output logic powerup_hold
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(PULSE_TICKS);

  logic [SYNC_STAGES:0] hi_sr, lo_sr, drv_hist;
  logic [CW-1:0] cnt;
  logic busy, sup_q, hold, drive, masked, ext_req, req;

  assign drive   = ~supply_ok | busy;
  assign masked  = drive | (|drv_hist);
  assign ext_req = ~masked & ((hi_sr[SYNC_STAGES-1] & ~hi_sr[SYNC_STAGES]) |
                              (~lo_sr[SYNC_STAGES-1] & lo_sr[SYNC_STAGES]));
  assign req     = ext_req | wdt_expire;

  assign rst_hi_oe    = drive;
  assign rst_lo_oe    = drive;
  assign reset_active = drive;
  assign powerup_hold = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_sr    <= '0;
      lo_sr    <= '1;
      drv_hist <= '1;
    end else begin
      hi_sr    <= {hi_sr[SYNC_STAGES-1:0], rst_hi_pin};
      lo_sr    <= {lo_sr[SYNC_STAGES-1:0], rst_lo_pin};
      drv_hist <= {drv_hist[SYNC_STAGES-1:0], drive};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      cnt   <= FULL;
      sup_q <= 1'b0;
      hold  <= 1'b0;
    end else begin
      sup_q <= supply_ok;
      if (!supply_ok) begin
        busy <= 1'b1;
        cnt  <= FULL;
        hold <= 1'b0;
      end else begin
        if (!sup_q) hold <= 1'b1;
        if (req) begin
          busy <= 1'b1;
          cnt  <= FULL;
        end else if (busy && tick) begin
          if (cnt <= CW'(1)) begin
            busy <= 1'b0;
            hold <= 1'b0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sup_reset_pulse_chk.sv
module sup_reset_pulse_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic supply_ok,
  input logic wdt_expire,
  input logic rst_hi_oe,
  input logic rst_lo_oe,
  input logic reset_active,
  input logic powerup_hold
);
  // R1
  supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (rst_hi_oe && rst_lo_oe));
  // R4
  wdt_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && wdt_expire) |=> (rst_hi_oe && reset_active));
  // R2
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hi_oe) |-> (supply_ok && $past(tick)));
  // R8
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && wdt_expire && tick) |=> rst_lo_oe);
  // R9
  hold_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powerup_hold |-> rst_lo_oe);
  // R9
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powerup_hold) |-> $past(supply_ok));
endmodule

bind sup_reset_pulse sup_reset_pulse_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
  .wdt_expire(wdt_expire), .rst_hi_oe(rst_hi_oe), .rst_lo_oe(rst_lo_oe),
  .reset_active(reset_active), .powerup_hold(powerup_hold)
);

// File: tb/sim_sup_reset_pulse.sv
`timescale 1ns/1ps
module sim_sup_reset_pulse;
  localparam int P = 5;
  logic clk = 0, rst_n = 0, tick = 0, supply_ok = 0, wdt_expire = 0;
  logic ext_hi = 0, ext_lo = 1;
  logic rst_hi_oe, rst_lo_oe, reset_active, powerup_hold;
  logic hi_pin, lo_pin;
  int errors = 0, checks = 0, tdiv = 0;
  bit done = 0;

  assign hi_pin = rst_hi_oe ? 1'b1 : ext_hi;
  assign lo_pin = rst_lo_oe ? 1'b0 : ext_lo;

  sup_reset_pulse #(.PULSE_TICKS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .wdt_expire(wdt_expire), .rst_hi_pin(hi_pin), .rst_lo_pin(lo_pin),
    .rst_hi_oe(rst_hi_oe), .rst_lo_oe(rst_lo_oe),
    .reset_active(reset_active), .powerup_hold(powerup_hold));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == 2) ? 0 : tdiv + 1;
    tick <= (tdiv == 2);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
    chk(rst_hi_oe == rst_lo_oe && rst_hi_oe == reset_active, "R3 polarity",
        int'(rst_lo_oe), int'(rst_hi_oe));
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int g = 0; g < 200 && rst_hi_oe; g++) begin
      if (tick) n++;
      step();
    end
  endtask

  task automatic quiet(input string req);
    int hi = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (rst_hi_oe) hi++;
    end
    chk(hi == 0, req, hi, 0);
  endtask

  task automatic t_reset();
    step();
    chk(rst_hi_oe && rst_lo_oe, "R10 outputs in reset", int'(rst_hi_oe), 1);
    chk(!powerup_hold, "R10 hold in reset", int'(powerup_hold), 0);
    rst_n = 1;
    step(); step();
    chk(rst_hi_oe, "R1 supply low keeps reset", int'(rst_hi_oe), 1);
  endtask

  task automatic t_powerup();
    int n;
    supply_ok = 1;
    chk(rst_hi_oe, "R2 asserted at rise", int'(rst_hi_oe), 1);
    measure(n);
    chk(n == P, "R2 power-up pulse ticks", n, P);
  endtask

  task automatic t_hold();
    int n, seen = 0, dropped = 0;
    supply_ok = 0; step();
    supply_ok = 1;
    step();
    chk(powerup_hold, "R9 hold after rise", int'(powerup_hold), 1);
    for (int g = 0; g < 200 && rst_hi_oe; g++) begin
      if (!powerup_hold) dropped++;
      step();
    end
    chk(dropped == 0, "R9 hold through pulse", dropped, 0);
    chk(!powerup_hold, "R9 hold cleared at end", int'(powerup_hold), 0);
    wdt_expire = 1; step(); wdt_expire = 0;
    if (powerup_hold) seen++;
    measure(n);
    chk(seen == 0, "R9 no hold for watchdog pulse", seen, 0);
  endtask

  task automatic t_supply_drop();
    int n;
    step();
    supply_ok = 0; #1;
    chk(rst_hi_oe && rst_lo_oe, "R1 immediate assert", int'(rst_hi_oe), 1);
    step(); step();
    chk(rst_lo_oe, "R1 held while low", int'(rst_lo_oe), 1);
    supply_ok = 1;
    measure(n);
    chk(n == P, "R2 pulse after recovery", n, P);
  endtask

  task automatic t_wdt();
    int n;
    step();
    wdt_expire = 1; step(); wdt_expire = 0;
    chk(rst_hi_oe, "R4 asserted next cycle", int'(rst_hi_oe), 1);
    measure(n);
    chk(n == P, "R4 watchdog pulse ticks", n, P);
    quiet("R7 no self retrigger after watchdog pulse");
  endtask

  task automatic t_coincide();
    int n = 0, m;
    step();
    wdt_expire = 1; step(); wdt_expire = 0;
    for (int g = 0; g < 200; g++) begin
      if (tick) begin
        if (n == P - 1) break;
        n++;
      end
      step();
    end
    wdt_expire = 1; step(); wdt_expire = 0;
    chk(rst_hi_oe, "R8 request wins over last tick", int'(rst_hi_oe), 1);
    measure(m);
    chk(m == P, "R8 reloaded pulse ticks", m, P);
  endtask

  task automatic t_ext_hi();
    int lat = 0, n;
    step();
    ext_hi = 1;
    for (int g = 0; g < 6 && !rst_hi_oe; g++) begin step(); lat++; end
    chk(lat <= 3 && rst_hi_oe, "R5 high pin edge latency", lat, 3);
    measure(n);
    chk(n == P, "R5 high pin pulse ticks", n, P);
    quiet("R7 no retrigger after high pin pulse");
    ext_hi = 0;
    quiet("R7 falling high pin ignored");
  endtask

  task automatic t_ext_lo();
    int lat = 0, n;
    step();
    ext_lo = 0;
    for (int g = 0; g < 6 && !rst_hi_oe; g++) begin step(); lat++; end
    chk(lat <= 3 && rst_lo_oe, "R6 low pin edge latency", lat, 3);
    measure(n);
    chk(n == P, "R6 low pin pulse ticks", n, P);
    ext_lo = 1;
    quiet("R7 rising low pin ignored");
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_wdt();
    t_coincide();
    t_ext_hi();
    t_ext_lo();
    t_hold();
    t_supply_drop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule